// File: doc/BRIEF.md
# Register-Controlled Shift Unit

A purely combinational 32-bit shifter for the integer execute stage of a load-store RISC datapath. It takes a source operand, a 5-bit shift field from the instruction word, a second register operand and a 6-bit function code. From these it produces the shifted result and a flag that says the function code named a shift.

Three shift kinds exist: left logical, right logical and right arithmetic. Each kind has two forms. The fixed form takes its distance from the instruction's shift field. The variable form takes its distance from the low five bits of the register operand. Rotates are not provided, because software builds them from two shifts and an OR. Register-file access and pipeline control belong to the surrounding datapath.

Top module: `shf_unit`

## Requirements
- R1: Function code 000000 shifts the source left by the shift field and fills the vacated low bits with zero.
- R2: Function code 000010 shifts the source right by the shift field and fills the vacated high bits with zero.
- R3: Function code 000011 shifts the source right by the shift field and fills the vacated high bits with copies of source bit 31.
- R4: Function codes 000100, 000110 and 000111 perform the left, right-logical and right-arithmetic shifts of R1 to R3. Their distance is register operand bits 4:0, and the shift field has no effect on them.
- R5: In the variable forms, register operand bits 31:5 have no effect on the result.
- R6: In the fixed forms, the register operand has no effect on the result.
- R7: The valid flag is 1 for exactly the six codes of R1 to R4. For every other code it is 0 and the result is all zeros.
- R8: A distance of 0 returns the source unchanged for all six shift codes.
- R9: For a source with bit 31 clear, the right-arithmetic result equals the right-logical result at every distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_src | input | 32 | Operand to be shifted |
| sh_imm | input | 5 | Shift distance field from the instruction |
| op_reg | input | 32 | Register operand; its low five bits give the variable distance |
| fn_code | input | 6 | Function code selecting the shift kind and the source of the distance |
| res_out | output | 32 | Shifted result, or zero for an invalid code |
| res_valid | output | 1 | High when fn_code names one of the six shifts |

## Verification
Every shift code is swept over all 32 distances. The sweep uses four sources: random negative values, random non-negative values, all ones, and a single set top bit. The all-ones and top-bit sources show the sign fill and the zero fill directly. The random sources catch a swapped or missing stage in the barrel. The variable forms are driven with random upper register bits and a shift field different from the real distance, so a wrong distance source shows as a wrong result. All 64 function codes are applied, which separates the six valid encodings from the 58 that must produce zero.

// File: rtl/shf_pkg.sv
// Package: shared types and function-code values for the shift unit.
// Assumes the datapath is 32 bits wide; the code values are fixed by the
// instruction encoding that the decoder expects.
package shf_pkg;
    localparam int FN_W = 6;

    typedef enum logic [1:0] {
        SK_LEFT   = 2'd0,
        SK_RLOG   = 2'd2,
        SK_RARITH = 2'd3
    } shf_kind_e;

    localparam logic [FN_W-1:0] FN_SLL  = 6'b000000;
    localparam logic [FN_W-1:0] FN_SRL  = 6'b000010;
    localparam logic [FN_W-1:0] FN_SRA  = 6'b000011;
    localparam logic [FN_W-1:0] FN_SLLV = 6'b000100;
    localparam logic [FN_W-1:0] FN_SRLV = 6'b000110;
    localparam logic [FN_W-1:0] FN_SRAV = 6'b000111;
endpackage

// File: rtl/shf_decode.sv
// Module: turns a function code into a shift kind, a distance-source select
// and a valid flag. Assumes codes outside the six shifts are simply not shifts.
module shf_decode
    import shf_pkg::*;
(
    input  logic [FN_W-1:0] fn_code,
    output shf_kind_e       kind,
    output logic            use_reg,
    output logic            valid
);
    // Map each recognised code; everything else is flagged invalid.
    always_comb begin
        kind    = SK_LEFT;
        use_reg = 1'b0;
        valid   = 1'b1;
        case (fn_code)
            FN_SLL:  kind = SK_LEFT;
            FN_SRL:  kind = SK_RLOG;
            FN_SRA:  kind = SK_RARITH;
            FN_SLLV: begin kind = SK_LEFT;   use_reg = 1'b1; end
            FN_SRLV: begin kind = SK_RLOG;   use_reg = 1'b1; end
            FN_SRAV: begin kind = SK_RARITH; use_reg = 1'b1; end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/shf_amount_sel.sv
// Module: picks the shift distance from the instruction field or from the
// low bits of the register operand. Assumes the caller passes only those low bits.
module shf_amount_sel #(
    parameter int AMT_W = 5
) (
    input  logic             use_reg,
    input  logic [AMT_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    output logic [AMT_W-1:0] amt
);
    // Choose the distance source.
    always_comb amt = use_reg ? reg_amt : imm_amt;
endmodule

// File: rtl/shf_barrel.sv
// Module: logarithmic barrel shifter. Left shifts are done as right shifts
// on the bit-reversed operand, so one stage chain serves all three kinds.
// Assumes DATA_W is a power of two.
module shf_barrel
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  shf_kind_e         kind,
    output logic [DATA_W-1:0] dout
);
    logic              is_left;
    logic              fill;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stg [AMT_W+1];

    // Decide direction and the bit shifted into vacated positions.
    always_comb begin
        is_left = (kind == SK_LEFT);
        fill    = (kind == SK_RARITH) & din[DATA_W-1];
    end

    // Bit reversal of the input and of the final stage.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign rev_in[b]  = din[DATA_W-1-b];
        assign rev_out[b] = stg[AMT_W][DATA_W-1-b];
    end

    // Feed the stage chain with the operand in shifting order.
    always_comb pre = is_left ? rev_in : din;
    assign stg[0] = pre;

    // One conditional right shift by a power of two per distance bit.
    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][DATA_W-1:STEP]} : stg[i];
    end

    // Undo the reversal for left shifts.
    always_comb dout = is_left ? rev_out : stg[AMT_W];
endmodule

// File: rtl/shf_unit.sv
// Module: top of the combinational shift unit. It decodes the function code,
// selects the distance, runs the barrel and forces zero for invalid codes.
// Assumes the operands are stable for as long as the result is used; there is
// no state and no reset.
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] op_src,
    input  logic [AMT_W-1:0]  sh_imm,
    input  logic [DATA_W-1:0] op_reg,
    input  logic [FN_W-1:0]   fn_code,
    output logic [DATA_W-1:0] res_out,
    output logic              res_valid
);
    shf_kind_e         kind;
    logic              use_reg;
    logic              dec_valid;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] shifted;
    logic              unused_reg_hi;

    // The upper register bits never set the distance.
    assign unused_reg_hi = ^op_reg[DATA_W-1:AMT_W];

    shf_decode u_dec (
        .fn_code (fn_code),
        .kind    (kind),
        .use_reg (use_reg),
        .valid   (dec_valid)
    );

    shf_amount_sel #(.AMT_W(AMT_W)) u_amt (
        .use_reg (use_reg),
        .imm_amt (sh_imm),
        .reg_amt (op_reg[AMT_W-1:0]),
        .amt     (amt)
    );

    shf_barrel #(.DATA_W(DATA_W)) u_bar (
        .din  (op_src),
        .amt  (amt),
        .kind (kind),
        .dout (shifted)
    );

    // Gate the result with the valid flag and check output invariants.
    always_comb begin
        res_valid = dec_valid;
        res_out   = dec_valid ? shifted : '0;

        assert_invalid_zero_R7: assert (dec_valid || res_out == '0);
        assert_zero_pass_R8: assert (!(dec_valid && amt == '0) || shifted == op_src);
        assert_sign_fill_R3: assert (!(dec_valid && kind == SK_RARITH && amt != '0)
                                     || shifted[DATA_W-1] == op_src[DATA_W-1]);
        assert_left_zero_R1: assert (!(dec_valid && kind == SK_LEFT && amt != '0)
                                     || shifted[0] == 1'b0);
        assert_right_zero_R2: assert (!(dec_valid && kind == SK_RLOG && amt != '0)
                                      || shifted[DATA_W-1] == 1'b0);
    end
endmodule

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;
    logic        clk = 1'b0;
    logic [31:0] op_src = '0;
    logic [4:0]  sh_imm = '0;
    logic [31:0] op_reg = '0;
    logic [5:0]  fn_code = '0;
    logic [31:0] res_out;
    logic        res_valid;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    shf_unit dut_i (
        .op_src    (op_src),
        .sh_imm    (sh_imm),
        .op_reg    (op_reg),
        .fn_code   (fn_code),
        .res_out   (res_out),
        .res_valid (res_valid)
    );

    // Expected value from the requirements using language shift operators.
    function automatic logic [32:0] model(input logic [5:0] fn, input logic [31:0] s,
                                          input logic [4:0] imm, input logic [31:0] r);
        logic [4:0] d;
        d = fn[2] ? r[4:0] : imm;
        case (fn)
            6'b000000, 6'b000100: return {1'b1, s << d};
            6'b000010, 6'b000110: return {1'b1, s >> d};
            6'b000011, 6'b000111: return {1'b1, 32'($signed(s) >>> d)};
            default:              return {1'b0, 32'h0};
        endcase
    endfunction

    task automatic apply_check(input logic [5:0] fn, input logic [31:0] s,
                               input logic [4:0] imm, input logic [31:0] r,
                               input string req);
        logic [32:0] exp;
        @(posedge clk);
        #1;
        fn_code = fn; op_src = s; sh_imm = imm; op_reg = r;
        #2;
        exp = model(fn, s, imm, r);
        total++;
        if ({res_valid, res_out} !== exp) begin
            bad++;
            $display("FAIL %s fn=%b src=%h imm=%0d reg=%h actual=%b/%h expected=%b/%h",
                     req, fn, s, imm, r, res_valid, res_out, exp[32], exp[31:0]);
        end
    endtask

    function automatic string req_of(input logic [5:0] fn, input int d);
        if (d == 0) return "R8";
        case (fn)
            6'b000000: return "R1";
            6'b000010: return "R2";
            6'b000011: return "R3";
            default:   return "R4";
        endcase
    endfunction

    initial begin
        logic [5:0] codes [6];
        codes[0] = 6'b000000; codes[1] = 6'b000010; codes[2] = 6'b000011;
        codes[3] = 6'b000100; codes[4] = 6'b000110; codes[5] = 6'b000111;
        // Idle inputs: sll by 0 of zero gives a valid zero result (R8).
        apply_check(6'b000000, 32'h0, 5'd0, 32'h0, "R8");
        // Reference patterns from the requirement examples (R1, R2, R3).
        apply_check(6'b000000, 32'h29, 5'd2, 32'h0, "R1");
        apply_check(6'b000010, 32'h29, 5'd2, 32'h0, "R2");
        apply_check(6'b000011, 32'hFFFF_FFF5, 5'd2, 32'h0, "R3");
        // Full sweep of codes, distances and operand classes.
        for (int c = 0; c < 6; c++) begin
            for (int d = 0; d < 32; d++) begin
                logic [31:0] hi_reg;
                logic [4:0]  other;
                hi_reg = $urandom() & 32'hFFFF_FFE0;
                other  = 5'(d + 1 + ($urandom() % 30));
                if (codes[c][2]) begin
                    // Variable forms: shift field differs, upper bits random (R4, R5).
                    apply_check(codes[c], $urandom() | 32'h8000_0000, other, hi_reg | 32'(d), req_of(codes[c], d));
                    apply_check(codes[c], $urandom() & 32'h7FFF_FFFF, other, hi_reg | 32'(d), "R5");
                    apply_check(codes[c], 32'hFFFF_FFFF, other, hi_reg | 32'(d), "R4");
                    apply_check(codes[c], 32'h8000_0000, 5'd0, 32'hFFFF_FFE0 | 32'(d), "R5");
                end else begin
                    // Fixed forms: random register operand must not matter (R6).
                    apply_check(codes[c], $urandom() | 32'h8000_0000, 5'(d), $urandom(), req_of(codes[c], d));
                    apply_check(codes[c], $urandom() & 32'h7FFF_FFFF, 5'(d), $urandom(), "R6");
                    apply_check(codes[c], 32'hFFFF_FFFF, 5'(d), 32'hFFFF_FFFF, req_of(codes[c], d));
                    apply_check(codes[c], 32'h8000_0000, 5'(d), $urandom(), "R6");
                end
            end
        end
        // R9: non-negative sources give the same result for sra and srl.
        for (int d = 0; d < 32; d++) begin
            logic [31:0] s;
            s = $urandom() & 32'h7FFF_FFFF;
            apply_check(6'b000011, s, 5'(d), 32'h0, "R9");
            apply_check(6'b000010, s, 5'(d), 32'h0, "R9");
        end
        // R7: every code outside the six shifts reports invalid and zero.
        for (int f = 0; f < 64; f++) begin
            apply_check(6'(f), 32'hDEAD_BEEF, 5'd7, 32'h0000_0003, "R7");
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule